// File: doc/BRIEF.md
# DMA Interrupt Control Register

This block is the shared interrupt control and status word of a seven-channel DMA engine. Software writes it to set per-channel interrupt enables, a master enable, a force bit and six general bits. Each channel engine reports the end of a transfer with a one-cycle done pulse. The register latches that pulse into a per-channel flag when that channel's enable is set. Software clears a flag by writing 1 to it.

Every cycle the register evaluates a master condition from the values it is about to store. The condition is true when the master enable is set and at least one flag is set, or when the force bit is set. The result is stored as the master flag in bit 31. A one-cycle request to the system interrupt controller is raised only when that flag goes from 0 to 1. The request is meant to set bit 3 of the system interrupt status. It is not raised again while the flag stays set. It can be raised again once the condition has dropped and then come back.

Top module: `dma_irq_ctrl`

## Requirements
- R1: Only bits 0..5, 15 (force), 16..22 (enables for channels 0..6) and 23 (master enable) take the written value on a write, which is mask 0x00FF803F. Written bits 6..14 are ignored and always read 0.
- R2: On a write, flag bit 24+n keeps its value where written bit 24+n is 0 and is cleared where written bit 24+n is 1.
- R3: The master condition is (bit 23 AND any of bits 24..30) OR bit 15, computed from the values being stored in that cycle. Flags set while bit 23 is 0 do not make the condition true.
- R4: Bit 31 is stored as the master condition, in the same clock edge as the write or flag change that decides it.
- R5: `irqReq` is high for one cycle, in the same cycle that bit 31 first reads 1, only when bit 31 was 0 before. It stays low while bit 31 stays 1.
- R6: A pulse on `chanDone[n]` sets flag bit 24+n at the next edge only if enable bit 16+n was already 1 before that edge. A pulse on a disabled channel has no effect.
- R7: When the condition becomes false, bit 31 reads 0, so that a later event raises a new request.
- R8: If a done pulse and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R9: After reset, `regOut` is 0x00000000 and `irqReq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Software write strobe |
| wrData | input | 32 | Software write value |
| chanDone | input | 7 | Per-channel transfer-done pulses |
| regOut | output | 32 | Current register value |
| irqReq | output | 1 | One-cycle request to set system interrupt status bit 3 |

## Verification
A wrong master flag shows at the ports in the cycle after the decisive write or done pulse. Either `regOut[31]` disagrees with the stored enable, flag and force bits, or `irqReq` pulses when it should stay quiet or misses its pulse. A flag that was wrongly set or wrongly kept shows up immediately in `regOut[30:24]`. It also shows one write later, as a master flag that fails to drop after the clearing write. The stimulus therefore reads the register and the request after every step, so that any wrong state is caught within one cycle.

// File: rtl/dicr_pkg.sv
package dicr_pkg;
  localparam int REG_W     = 32;
  localparam int NUM_CH    = 7;
  localparam int SW_W      = 6;
  localparam int FORCE_BIT = 15;
  localparam int ENA_LO    = FORCE_BIT + 1;
  localparam int MEN_BIT   = ENA_LO + NUM_CH;
  localparam int FLG_LO    = MEN_BIT + 1;
  localparam int MFLAG_BIT = FLG_LO + NUM_CH;
  localparam int GAP_W     = FORCE_BIT - SW_W;

  typedef struct packed {
    logic              load;
    logic [NUM_CH-1:0] clrMask;
    logic [NUM_CH-1:0] setMask;
  } dicrStrobe_t;
endpackage

// File: rtl/dicr_ctrl.sv
module dicr_ctrl
  import dicr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     wrEn,
  input  logic [REG_W-1:0]         wrData,
  input  logic [NUM_CH-1:0]        chanDone,
  input  logic [NUM_CH-1:0]        chanEna,
  input  logic                     condNext,
  input  logic                     masterFlag,
  output dicrStrobe_t              strobe,
  output logic                     irqReq
);
  // per-channel gating of done pulses and write-1 clears
  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    always_comb begin
      strobe.setMask[n] = chanDone[n] & chanEna[n];
      strobe.clrMask[n] = wrEn & wrData[FLG_LO + n];
    end
  end

  always_comb strobe.load = wrEn;

  // rising-edge request: master flag about to go 0 -> 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqReq <= 1'b0;
    else       irqReq <= condNext & ~masterFlag;
  end
endmodule

// File: rtl/dicr_datapath.sv
module dicr_datapath
  import dicr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [REG_W-1:0]   wrData,
  input  dicrStrobe_t        strobe,
  output logic [REG_W-1:0]   regOut,
  output logic [NUM_CH-1:0]  chanEna,
  output logic               condNext,
  output logic               masterFlag
);
  logic [SW_W-1:0]   swBits,  swBitsNext;
  logic              forceBit, forceNext;
  logic              masterEn, masterEnNext;
  logic [NUM_CH-1:0] enaNext;
  logic [NUM_CH-1:0] flags,   flagsNext;

  always_comb begin
    swBitsNext   = strobe.load ? wrData[SW_W-1:0]            : swBits;
    forceNext    = strobe.load ? wrData[FORCE_BIT]           : forceBit;
    enaNext      = strobe.load ? wrData[ENA_LO +: NUM_CH]    : chanEna;
    masterEnNext = strobe.load ? wrData[MEN_BIT]             : masterEn;
  end

  // one flag cell per channel; a set beats a clear
  for (genvar n = 0; n < NUM_CH; n++) begin : g_flag
    always_comb flagsNext[n] = strobe.setMask[n] | (flags[n] & ~strobe.clrMask[n]);
  end

  always_comb condNext = (masterEnNext & (|flagsNext)) | forceNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      swBits     <= '0;
      forceBit   <= 1'b0;
      chanEna    <= '0;
      masterEn   <= 1'b0;
      flags      <= '0;
      masterFlag <= 1'b0;
    end else begin
      swBits     <= swBitsNext;
      forceBit   <= forceNext;
      chanEna    <= enaNext;
      masterEn   <= masterEnNext;
      flags      <= flagsNext;
      masterFlag <= condNext;
    end
  end

  always_comb regOut = {masterFlag, flags, masterEn, chanEna, forceBit, {GAP_W{1'b0}}, swBits};
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
  import dicr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  logic [6:0]        chanDone,
  output logic [31:0]       regOut,
  output logic              irqReq
);
  dicrStrobe_t       strobe;
  logic [NUM_CH-1:0] chanEna;
  logic              condNext;
  logic              masterFlag;

  dicr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .chanDone(chanDone),
    .chanEna(chanEna), .condNext(condNext), .masterFlag(masterFlag),
    .strobe(strobe), .irqReq(irqReq)
  );

  dicr_datapath u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .strobe(strobe),
    .regOut(regOut), .chanEna(chanEna), .condNext(condNext), .masterFlag(masterFlag)
  );
endmodule

// File: rtl/dicr_checker.sv
module dicr_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [6:0]  chanDone,
  input logic [31:0] regOut,
  input logic        irqReq
);
  AST_IRQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> regOut[31]); // R5
  AST_IRQ_FROM_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> !$past(regOut[31])); // R5
  AST_NO_REPEAT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (regOut[31] && $past(regOut[31])) |-> !irqReq); // R5
  AST_MASTER_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    regOut[31] == ((regOut[23] && |regOut[30:24]) || regOut[15])); // R4
  AST_FLAG_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regOut[24]) |-> $past(chanDone[0] && regOut[16])); // R6
  AST_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[24] && !chanDone[0]) |=> !regOut[24]); // R2
  AST_GAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regOut[14:6] == 9'd0); // R1
endmodule

bind dma_irq_ctrl dicr_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
  .chanDone(chanDone), .regOut(regOut), .irqReq(irqReq)
);

// File: tb/sim_dma_irq_ctrl.sv
`timescale 1ns/1ps
module sim_dma_irq_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [6:0]  chanDone = '0;
  logic [31:0] regOut;
  logic        irqReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dma_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .chanDone(chanDone), .regOut(regOut), .irqReq(irqReq)
  );

  // {wrEn, wrData, chanDone, expected regOut, expected irqReq}
  localparam int NV = 17;
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 32'hFFFFFFFF, 7'h00, 32'h80FF803F, 1'b1}, // R1 mask, force -> R5
    {1'b0, 32'h00000000, 7'h00, 32'h80FF803F, 1'b0}, // R5 one shot
    {1'b1, 32'h00800000, 7'h00, 32'h00800000, 1'b0}, // R7 drop
    {1'b0, 32'h00000000, 7'h01, 32'h00800000, 1'b0}, // R6 disabled channel
    {1'b1, 32'h00810000, 7'h00, 32'h00810000, 1'b0},
    {1'b0, 32'h00000000, 7'h01, 32'h81810000, 1'b1}, // R6 set, R4
    {1'b0, 32'h00000000, 7'h01, 32'h81810000, 1'b0}, // R5
    {1'b1, 32'h00830000, 7'h00, 32'h81830000, 1'b0}, // R2 keep
    {1'b0, 32'h00000000, 7'h02, 32'h83830000, 1'b0}, // R5 no repeat
    {1'b1, 32'h01830000, 7'h00, 32'h82830000, 1'b0}, // R2 clear one
    {1'b1, 32'h02830000, 7'h00, 32'h00830000, 1'b0}, // R7
    {1'b1, 32'h00030000, 7'h00, 32'h00030000, 1'b0},
    {1'b0, 32'h00000000, 7'h02, 32'h02030000, 1'b0}, // R3 needs master enable
    {1'b1, 32'h00838000, 7'h00, 32'h82838000, 1'b1}, // R3 R4 R5
    {1'b1, 32'h7F000000, 7'h00, 32'h00000000, 1'b0}, // R2 clear all, R7
    {1'b1, 32'h007F7FC0, 7'h00, 32'h007F0000, 1'b0}, // R1 ignored bits
    {1'b1, 32'h40FF0000, 7'h40, 32'hC0FF0000, 1'b1}  // R8 set beats clear
  };

  task automatic check(input string req, input logic [31:0] expReg, input logic expIrq);
    checks++;
    if (regOut !== expReg || irqReq !== expIrq) begin
      fails++;
      $display("FAIL %s: regOut=%08h irqReq=%0b expected regOut=%08h irqReq=%0b",
               req, regOut, irqReq, expReg, expIrq);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R9", 32'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9", 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      wrEn     = VEC[i][72];
      wrData   = VEC[i][71:40];
      chanDone = VEC[i][39:33];
      @(negedge clk);
      wrEn = 1'b0; chanDone = '0;
      check($sformatf("R1-vector %0d", i), VEC[i][32:1], VEC[i][0]);
    end

    // the request comes back after the condition drops and returns (R7)
    wrEn = 1'b1; wrData = 32'h40FF0000; @(negedge clk); wrEn = 1'b0;
    check("R7 drop", 32'h00FF0000, 1'b0);
    chanDone = 7'h40; @(negedge clk); chanDone = '0;
    check("R7 re-raise", 32'hC0FF0000, 1'b1);

    // reset in the middle of a run (R9)
    rstN = 1'b0; @(negedge clk);
    check("R9 async", 32'h0, 1'b0);
    rstN = 1'b1; @(negedge clk);
    check("R9 idle", 32'h0, 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule